// File: doc/BRIEF.md
# Guest Fence-Ordering Widening Unit

This block keeps a 64-bit environment-configuration register that a hypervisor programs for its guests, and uses one bit of it, the "I/O ordering implies memory ordering" bit, to strengthen memory-ordering requests made while the hart runs virtualized. Software reaches the register through a CSR read/write port. A parameter selects the port width. With a 64-bit port one address covers the whole register. With a 32-bit port the register is split into a low word and a high word, each at its own address.

Every cycle the block receives the current virtualization mode, the decoded predecessor and successor sets of a FENCE, and the attributes of an atomic access. It returns the effective ordering sets and a flag that tells whether the atomic must also be ordered against main memory. When the ordering bit is set and the hart is virtualized, each device-input request also requests memory reads and each device-output request also requests memory writes. An I/O atomic that carries acquire or release semantics is also flagged for memory ordering. In every other case the fence sets pass through unchanged and no atomic is flagged. All outputs except the register state are combinational.

Top module: `fence_order_expand`

## Requirements
- R1: After reset the register reads as all zeros, so neither the fence sets nor the atomic flag are widened.
- R2: Only bit 0 (I/O-implies-memory), bits 5:4 (cache-invalidate control), bit 6 (cache-flush control), bit 7 (cache-zero control) and bit 63 (guest timer control) are stored. All other bits read as zero and ignore writes.
- R3: With a 64-bit port, a write to the low address updates all 64 bits, and a read of the low address returns all 64 bits.
- R4: With a 32-bit port, the low address reads and writes bits 31:0 and the high address reads and writes bits 63:32. A write to one half leaves the other half unchanged.
- R5: With a 64-bit port, any access to the high address raises csr_err in the same cycle, returns zero and leaves the register unchanged.
- R6: When bit 0 is clear or virt_mode is low, eff_pred equals fence_pred and eff_succ equals fence_succ.
- R7: Fence sets are encoded as bit 3 = device input, bit 2 = device output, bit 1 = memory read, bit 0 = memory write. When bit 0 is set and virt_mode is high, predecessor bit 3 also sets eff_pred bit 1, and predecessor bit 2 also sets eff_pred bit 0. No set bit is ever dropped.
- R8: Under the same condition, successor bit 3 also sets eff_succ bit 1, and successor bit 2 also sets eff_succ bit 0.
- R9: amo_mem_order is high when bit 0 is set, virt_mode is high, amo_dev_io is high and at least one of amo_aq or amo_rl is high.
- R10: amo_mem_order stays low for an atomic that is not to device I/O, or that has neither aq nor rl, even when widening is active.
- R11: A write takes effect on the next clock edge. A read in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_write | input | 1 | Access is a write |
| csr_addr | input | AW | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, zero when no register is selected |
| csr_err | output | 1 | Illegal access to the high half in 64-bit mode |
| virt_mode | input | 1 | Hart is running a guest |
| fence_pred | input | 4 | Decoded predecessor set {in, out, rd, wr} |
| fence_succ | input | 4 | Decoded successor set {in, out, rd, wr} |
| eff_pred | output | 4 | Effective predecessor set |
| eff_succ | output | 4 | Effective successor set |
| amo_aq | input | 1 | Atomic has acquire semantics |
| amo_rl | input | 1 | Atomic has release semantics |
| amo_dev_io | input | 1 | Atomic targets a device-I/O region |
| amo_mem_order | output | 1 | Atomic must also be ordered against memory |

## Verification
All sixteen predecessor and successor codes are applied under each of the four combinations of the ordering bit and virt_mode. This separates plain pass-through from widening, and shows that widening only adds the memory bit paired with each I/O bit. All eight atomic attribute combinations are applied in the widened and the non-widened state, which isolates the gating by the I/O region, by acquire/release and by mode. A 64-bit and a 32-bit instance receive the same all-ones, all-zeros and split-half write patterns. These show the reserved-bit masking, the independence of the two halves and the rejection of the high address in 64-bit mode. A long random phase then mixes writes, illegal accesses and fence traffic against the bench's own model.

// File: rtl/fox_pkg.sv
package fox_pkg;

   localparam int CFG_W          = 64;
   localparam int FENCE_W        = 4;
   localparam int IO_MEM_BIT     = 0;
   localparam int CACHE_INV_LSB  = 4;
   localparam int CACHE_INV_MSB  = 5;
   localparam int CACHE_FLUSH_BIT = 6;
   localparam int CACHE_ZERO_BIT = 7;
   localparam int GUEST_TMR_BIT  = 63;

   // fence set encoding: [3] device in, [2] device out, [1] mem read, [0] mem write
   localparam int F_DEV_IN  = 3;
   localparam int F_DEV_OUT = 2;
   localparam int F_MEM_RD  = 1;
   localparam int F_MEM_WR  = 0;

   function automatic logic [CFG_W-1:0] cfg_keep_mask();
      logic [CFG_W-1:0] m;
      m = '0;
      m[IO_MEM_BIT]      = 1'b1;
      for (int b = CACHE_INV_LSB; b <= CACHE_INV_MSB; b++) m[b] = 1'b1;
      m[CACHE_FLUSH_BIT] = 1'b1;
      m[CACHE_ZERO_BIT]  = 1'b1;
      m[GUEST_TMR_BIT]   = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/fox_envcfg_regs.sv
module fox_envcfg_regs
   import fox_pkg::*;
#(
   parameter int            XLEN    = 64,
   parameter int            AW      = 12,
   parameter logic [AW-1:0] LO_ADDR = 12'h60A,
   parameter logic [AW-1:0] HI_ADDR = 12'h61A
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_valid,
   input  logic             csr_write,
   input  logic [AW-1:0]    csr_addr,
   input  logic [XLEN-1:0]  csr_wdata,
   output logic [XLEN-1:0]  csr_rdata,
   output logic             csr_err,
   output logic [CFG_W-1:0] cfg_q
);

   localparam logic [CFG_W-1:0] KEEP = cfg_keep_mask();
   localparam int HALF = CFG_W / 2;

   logic             sel_lo;
   logic             sel_hi;
   logic [CFG_W-1:0] cfg_d;

   assign sel_lo = csr_valid && (csr_addr == LO_ADDR);
   assign sel_hi = csr_valid && (csr_addr == HI_ADDR);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("fox_envcfg_regs: XLEN must be 32 or 64");
   end
   if (LO_ADDR == HI_ADDR) begin : g_bad_addr
      $error("fox_envcfg_regs: low and high addresses must differ");
   end

   if (XLEN == CFG_W) begin : g_wide
      logic [CFG_W-1:0] wd;
      assign wd = CFG_W'(csr_wdata);
      always_comb begin
         cfg_d = cfg_q;
         if (sel_lo && csr_write) cfg_d = wd;
      end
      assign csr_rdata = sel_lo ? XLEN'(cfg_q) : '0;
      assign csr_err   = sel_hi;
   end else begin : g_split
      logic [HALF-1:0] wd;
      assign wd = HALF'(csr_wdata);
      always_comb begin
         cfg_d = cfg_q;
         if (csr_write && sel_lo) cfg_d = {cfg_q[CFG_W-1:HALF], wd};
         if (csr_write && sel_hi) cfg_d = {wd, cfg_q[HALF-1:0]};
      end
      always_comb begin
         csr_rdata = '0;
         if (sel_lo) csr_rdata = XLEN'(cfg_q[HALF-1:0]);
         if (sel_hi) csr_rdata = XLEN'(cfg_q[CFG_W-1:HALF]);
      end
      assign csr_err = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d & KEEP;
   end

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q & ~KEEP) == '0);  // R2

   AST_ERR_IFF_HI: assert property (@(posedge clk) disable iff (!rst_n)
      csr_err |-> (sel_hi && XLEN == CFG_W));  // R5

   if (XLEN == CFG_W) begin : g_hi_chk
      AST_HI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_hi && csr_write) |=> $stable(cfg_q));  // R5
   end else begin : g_half_chk
      AST_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_lo && csr_write) |=> $stable(cfg_q[CFG_W-1:HALF]));  // R4
   end

endmodule

// File: rtl/fox_fence_widen.sv
module fox_fence_widen
   import fox_pkg::*;
#(
   parameter int NSETS = 2
)(
   input  logic                          widen,
   input  logic [NSETS-1:0][FENCE_W-1:0] set_i,
   output logic [NSETS-1:0][FENCE_W-1:0] set_o
);

   if (NSETS < 1) begin : g_bad
      $error("fox_fence_widen: NSETS must be at least 1");
   end

   for (genvar g = 0; g < NSETS; g++) begin : g_set
      logic [FENCE_W-1:0] extra;
      always_comb begin
         extra = '0;
         extra[F_MEM_RD] = set_i[g][F_DEV_IN];
         extra[F_MEM_WR] = set_i[g][F_DEV_OUT];
      end
      assign set_o[g] = set_i[g] | (widen ? extra : '0);
   end

endmodule

// File: rtl/fox_amo_order.sv
module fox_amo_order (
   input  logic widen,
   input  logic aq,
   input  logic rl,
   input  logic dev_io,
   output logic mem_order
);

   logic ordered;
   assign ordered   = aq | rl;
   assign mem_order = widen & dev_io & ordered;

endmodule

// File: rtl/fence_order_expand.sv
module fence_order_expand
   import fox_pkg::*;
#(
   parameter int            XLEN    = 64,
   parameter int            AW      = 12,
   parameter logic [AW-1:0] LO_ADDR = 12'h60A,
   parameter logic [AW-1:0] HI_ADDR = 12'h61A
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_valid,
   input  logic            csr_write,
   input  logic [AW-1:0]   csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   output logic            csr_err,
   input  logic            virt_mode,
   input  logic [3:0]      fence_pred,
   input  logic [3:0]      fence_succ,
   output logic [3:0]      eff_pred,
   output logic [3:0]      eff_succ,
   input  logic            amo_aq,
   input  logic            amo_rl,
   input  logic            amo_dev_io,
   output logic            amo_mem_order
);

   logic [CFG_W-1:0]        cfg_q;
   logic                    widen;
   logic [1:0][FENCE_W-1:0] sets_in;
   logic [1:0][FENCE_W-1:0] sets_out;

   fox_envcfg_regs #(
      .XLEN(XLEN), .AW(AW), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .csr_valid(csr_valid), .csr_write(csr_write),
      .csr_addr(csr_addr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .csr_err(csr_err),
      .cfg_q(cfg_q)
   );

   assign widen = cfg_q[IO_MEM_BIT] & virt_mode;

   assign sets_in[0] = fence_pred;
   assign sets_in[1] = fence_succ;

   fox_fence_widen #(.NSETS(2)) u_widen (
      .widen(widen), .set_i(sets_in), .set_o(sets_out)
   );

   assign eff_pred = sets_out[0];
   assign eff_succ = sets_out[1];

   fox_amo_order u_amo (
      .widen(widen), .aq(amo_aq), .rl(amo_rl), .dev_io(amo_dev_io),
      .mem_order(amo_mem_order)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (cfg_q == '0));  // R1

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_q[IO_MEM_BIT] && virt_mode) |-> (eff_pred == fence_pred && eff_succ == fence_succ));  // R6

   AST_PRED_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[IO_MEM_BIT] && virt_mode && fence_pred[F_DEV_IN]) |-> eff_pred[F_MEM_RD]);  // R7

   AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ((eff_pred & fence_pred) == fence_pred) && ((eff_succ & fence_succ) == fence_succ));  // R7

   AST_SUCC_WIDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[IO_MEM_BIT] && virt_mode && fence_succ[F_DEV_OUT]) |-> eff_succ[F_MEM_WR]);  // R8

   AST_AMO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      amo_mem_order |-> (virt_mode && cfg_q[IO_MEM_BIT]));  // R9

   AST_AMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!amo_dev_io || !(amo_aq || amo_rl)) |-> !amo_mem_order);  // R10

endmodule

// File: tb/tb_fence_order_expand.sv
`timescale 1ns/1ps
module tb_fence_order_expand;

   localparam int          AW   = 12;
   localparam logic [11:0] LO   = 12'h60A;
   localparam logic [11:0] HI   = 12'h61A;
   localparam logic [63:0] MASK = 64'h8000_0000_0000_00F1; // R2: bits 63, 7:4, 0

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n;
   logic        v, w, vm, aq, rl, io;
   logic [11:0] a;
   logic [63:0] d;
   logic [3:0]  p, s;

   logic [63:0] rd64;
   logic [31:0] rd32;
   logic        err64, err32, amo64, amo32;
   logic [3:0]  ep64, es64, ep32, es32;

   fence_order_expand #(.XLEN(64), .AW(AW), .LO_ADDR(LO), .HI_ADDR(HI)) dut (
      .clk(clk), .rst_n(rst_n), .csr_valid(v), .csr_write(w), .csr_addr(a),
      .csr_wdata(d), .csr_rdata(rd64), .csr_err(err64), .virt_mode(vm),
      .fence_pred(p), .fence_succ(s), .eff_pred(ep64), .eff_succ(es64),
      .amo_aq(aq), .amo_rl(rl), .amo_dev_io(io), .amo_mem_order(amo64));

   fence_order_expand #(.XLEN(32), .AW(AW), .LO_ADDR(LO), .HI_ADDR(HI)) dut32 (
      .clk(clk), .rst_n(rst_n), .csr_valid(v), .csr_write(w), .csr_addr(a),
      .csr_wdata(d[31:0]), .csr_rdata(rd32), .csr_err(err32), .virt_mode(vm),
      .fence_pred(p), .fence_succ(s), .eff_pred(ep32), .eff_succ(es32),
      .amo_aq(aq), .amo_rl(rl), .amo_dev_io(io), .amo_mem_order(amo32));

   logic [63:0] m64 = '0;
   logic [63:0] m32 = '0;
   int checks = 0;
   int errors = 0;
   bit after_reset = 1'b0;

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] widen_set(logic [3:0] x, bit e);
      return e ? (x | {2'b00, x[3:2]}) : x;
   endfunction

   task automatic cmp_fence(string inst, logic [63:0] m, logic [3:0] ep, logic [3:0] es, logic am);
      bit e;
      logic [3:0] xp, xs;
      logic xa;
      e  = m[0] && vm;
      xp = widen_set(p, e);
      xs = widen_set(s, e);
      xa = e && io && (aq || rl);
      chk(ep === xp, e ? "R7" : "R6", {inst, " eff_pred"}, 64'(ep), 64'(xp));
      chk(es === xs, e ? "R8" : "R6", {inst, " eff_succ"}, 64'(es), 64'(xs));
      chk(am === xa, xa ? "R9" : "R10", {inst, " amo_mem_order"}, 64'(am), 64'(xa));
   endtask

   task automatic step(bit iv, bit iw, logic [11:0] ia, logic [63:0] id, bit ivm,
                       logic [3:0] ip, logic [3:0] is, bit iaq, bit irl, bit iio);
      logic [63:0] x64, x32;
      logic [63:0] n64, n32;
      string tg;
      @(negedge clk);
      v = iv; w = iw; a = ia; d = id; vm = ivm; p = ip; s = is;
      aq = iaq; rl = irl; io = iio;
      #1;
      x64 = (v && a == LO) ? m64 : 64'h0;
      tg = after_reset ? "R1" : (v && w) ? "R11" : (v && a == HI) ? "R5" : "R3";
      chk(rd64 === x64, tg, "dut csr_rdata", rd64, x64);
      chk(err64 === (v && a == HI), "R5", "dut csr_err", 64'(err64), 64'(v && a == HI));
      x32 = (v && a == LO) ? {32'h0, m32[31:0]} : (v && a == HI) ? {32'h0, m32[63:32]} : 64'h0;
      tg = after_reset ? "R1" : (v && w) ? "R11" : "R4";
      chk(64'(rd32) === x32, tg, "dut32 csr_rdata", 64'(rd32), x32);
      chk(err32 === 1'b0, "R4", "dut32 csr_err", 64'(err32), 64'h0);
      cmp_fence("dut", m64, ep64, es64, amo64);
      cmp_fence("dut32", m32, ep32, es32, amo32);
      n64 = m64;
      n32 = m32;
      if (v && w && a == LO) n64 = d & MASK;
      if (v && w && a == LO) n32 = {m32[63:32], d[31:0]} & MASK;
      if (v && w && a == HI) n32 = {d[31:0], m32[31:0]} & MASK;
      @(posedge clk);
      m64 = n64;
      m32 = n32;
      after_reset = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      v = 0; w = 0; a = '0; d = '0; vm = 0; p = '0; s = '0; aq = 0; rl = 0; io = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state, read both halves with widening conditions present
      after_reset = 1'b1;
      step(1, 0, LO, '0, 1, 4'hC, 4'hC, 1, 1, 1);
      after_reset = 1'b1;
      step(1, 0, HI, '0, 1, 4'hF, 4'h4, 1, 0, 1);
      // R2 R3 R4 R11: all-ones write to low, then read back
      step(1, 1, LO, '1, 0, 4'h0, 4'h0, 0, 0, 0);
      step(1, 0, LO, '0, 0, 4'h0, 4'h0, 0, 0, 0);
      // R4: high half of 32-bit view; R5: high address rejected in 64-bit view
      step(1, 1, HI, '1, 0, 4'h0, 4'h0, 0, 0, 0);
      step(1, 0, HI, '0, 0, 4'h0, 4'h0, 0, 0, 0);
      step(1, 0, LO, '0, 0, 4'h0, 4'h0, 0, 0, 0);
      step(1, 1, HI, '0, 0, 4'h0, 4'h0, 0, 0, 0);
      step(1, 0, LO, '0, 0, 4'h0, 4'h0, 0, 0, 0);
      step(1, 0, HI, '0, 0, 4'h0, 4'h0, 0, 0, 0);
      // R6 R7 R8: every fence code under all four bit/mode combinations
      for (int cfg = 0; cfg < 2; cfg++) begin
         step(1, 1, LO, 64'(cfg), 0, 4'h0, 4'h0, 0, 0, 0);
         for (int mode = 0; mode < 2; mode++) begin
            for (int code = 0; code < 16; code++) begin
               step(0, 0, LO, '0, mode[0], code[3:0], 4'(15 - code), 0, 0, 0);
            end
            // R9 R10: all atomic attribute combinations
            for (int at = 0; at < 8; at++) begin
               step(0, 0, LO, '0, mode[0], 4'h0, 4'h0, at[0], at[1], at[2]);
            end
         end
      end
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] ra;
         logic [2:0]  sel;
         sel = 3'($urandom_range(0, 4));
         ra  = (sel < 2) ? LO : (sel < 4) ? HI : 12'h123;
         step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ra,
              {$urandom, $urandom}, $urandom_range(0, 1) == 1,
              4'($urandom), 4'($urandom),
              $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1);
      end
      summary();
      $finish;
   end

endmodule